// File: doc/BRIEF.md
# Addressed Serial Frame Receiver

This block receives asynchronous serial frames from a line that several nodes share. It works from a baud enable that pulses sixteen times per bit period. It finds the falling edge of each start bit and checks the start bit again at its centre to reject short glitches. It then samples every later bit at its centre and rebuilds the character. Completed characters go into a holding register, and a level interrupt asks the host to fetch them. A bad stop bit and a lost character each set a sticky error flag, and either flag drives an error interrupt.

When the multiprocessor format is selected, each frame carries one more bit after the data. This bit marks the frame as a node-address frame or as a payload frame. The receiver keeps one "selected" state bit. An address frame that equals the local node number sets this bit, and any other address frame clears it. Payload frames reach the host only while the node is selected. The matching address frame is itself delivered, so the host learns that it has been selected. In plain format every well-formed frame is delivered.

Top module: `mp_serial_rx`

## Requirements
- R1: After reset, `rx_full`, `rx_irq`, `frame_err`, `overrun_err` and `err_irq` are 0 and `rx_data` is 0.
- R2: In plain format (`mp_mode`=0), a frame is a 0 start bit, 8 data bits least significant first and a 1 stop bit. On completion, `rx_data` takes the byte and `rx_full` and `rx_irq` become 1.
- R3: A one-cycle `rd_strobe` pulse clears `rx_full` and `rx_irq` to 0.
- R4: A stop bit sampled as 0 sets `frame_err` and `err_irq`, and it leaves `rx_data` and `rx_full` unchanged.
- R5: If a frame that would be delivered completes while `rx_full` is 1, `overrun_err` and `err_irq` become 1 and `rx_data` keeps the older byte.
- R6: A low pulse on `rxd` that is much shorter than half a bit period starts no frame.
- R7: In multiprocessor format (`mp_mode`=1), one extra bit follows the 8 data bits and comes before the stop bit. The value 1 marks an address frame and 0 marks a payload frame.
- R8: After `mp_mode` goes to 1, payload frames are not delivered until a matching address frame arrives.
- R9: An address frame equal to `node_id` is delivered (it is loaded into `rx_data` and sets `rx_full`), and the payload frames after it are delivered.
- R10: An address frame that differs from `node_id` in any bit is not delivered, and the payload frames after it are discarded until the next address frame.
- R11: A one-cycle `err_clr` pulse clears `frame_err` and `overrun_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | Enable at 16 times the bit rate |
| rxd | input | 1 | Serial line, idles high |
| mp_mode | input | 1 | 1 selects the multiprocessor format with address filtering |
| node_id | input | 8 | Local node number |
| rd_strobe | input | 1 | Host has read `rx_data` |
| err_clr | input | 1 | Clears both error flags |
| rx_data | output | 8 | Last delivered character |
| rx_full | output | 1 | Character waiting for the host |
| rx_irq | output | 1 | Receive interrupt request |
| frame_err | output | 1 | Sticky bad-stop-bit flag |
| overrun_err | output | 1 | Sticky lost-character flag |
| err_irq | output | 1 | Error interrupt request |

## Verification
All 256 byte values are sent in plain format, each followed by a read. This exposes any bit-order, bit-position or stuck-bit fault in the character path. Address frames are sent that differ from the node number in exactly one bit, for each of the eight positions, and each is followed by a payload frame. This shows whether every bit of the compare is used and whether a mismatch really deselects the node. Directed sequences then cover the other cases: payload frames before any address frame, the sequence from selected to deselected and back, a bad stop bit, a glitch on the line, and a second character that arrives before the first was read.

// File: rtl/mp_rx_pkg.sv
// Package: shared types for the addressed serial receiver.
package mp_rx_pkg;

    // Bit-level receive state
    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_START = 3'd1,
        RX_DATA  = 3'd2,
        RX_MPB   = 3'd3,
        RX_STOP  = 3'd4
    } rx_state_e;

endpackage

// File: rtl/mp_rx_sampler.sv
// Module: mp_rx_sampler
// Synchronises the serial line and rebuilds one frame from it. Each bit is
// sampled at its centre from an oversampling enable. The start bit is
// checked again at half a bit time, and a high line there counts as a glitch.
// Assumes: tick pulses OVS times per bit; mp_mode is steady during a frame.
module mp_rx_sampler
    import mp_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic              mp_mode,
    output logic              frm_valid,
    output logic [DATA_W-1:0] frm_data,
    output logic              frm_mpb,
    output logic              frm_stop_ok
);

    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OVS / 2 - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    logic [1:0]        sync_q;
    logic              rx_s;
    rx_state_e         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] shift_q;
    logic              mpb_q;

    assign rx_s = sync_q[1];

    // Two-flop synchroniser on the asynchronous line
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end

    // Frame state machine driven by the oversampling enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= RX_IDLE;
            cnt_q       <= '0;
            idx_q       <= '0;
            shift_q     <= '0;
            mpb_q       <= 1'b0;
            frm_valid   <= 1'b0;
            frm_data    <= '0;
            frm_mpb     <= 1'b0;
            frm_stop_ok <= 1'b0;
        end else begin
            frm_valid <= 1'b0;
            if (tick) begin
                case (state_q)
                    RX_IDLE: begin
                        if (!rx_s) begin
                            state_q <= RX_START;
                            cnt_q   <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt_q == CNT_HALF) begin
                            cnt_q   <= '0;
                            idx_q   <= '0;
                            mpb_q   <= 1'b0;
                            state_q <= rx_s ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt_q == CNT_LAST) begin
                            cnt_q   <= '0;
                            shift_q <= {rx_s, shift_q[DATA_W-1:1]};
                            if (idx_q == IDX_LAST) state_q <= mp_mode ? RX_MPB : RX_STOP;
                            else                   idx_q   <= idx_q + 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_MPB: begin
                        if (cnt_q == CNT_LAST) begin
                            cnt_q   <= '0;
                            mpb_q   <= rx_s;
                            state_q <= RX_STOP;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt_q == CNT_LAST) begin
                            cnt_q       <= '0;
                            frm_valid   <= 1'b1;
                            frm_data    <= shift_q;
                            frm_mpb     <= mpb_q;
                            frm_stop_ok <= rx_s;
                            state_q     <= RX_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: state_q <= RX_IDLE;
                endcase
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> !frm_valid); // R2

endmodule

// File: rtl/mp_rx_filter.sv
// Module: mp_rx_filter
// Decides whether a completed frame goes to the host. In plain format every
// well-formed frame is delivered. In multiprocessor format an address frame
// is delivered only on a match, and a payload frame only while selected.
// Assumes: one-cycle frame pulses from the sampler.
module mp_rx_filter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mp_mode,
    input  logic [DATA_W-1:0] node_id,
    input  logic              frm_valid,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              frm_mpb,
    input  logic              frm_stop_ok,
    output logic              deliver,
    output logic              fe_set
);

    logic selected_q;
    logic good_frame;
    logic id_hit;

    assign good_frame = frm_valid && frm_stop_ok;
    assign id_hit     = (frm_data == node_id);

    // Selection state: cleared outside multiprocessor mode, updated on address frames
    always_ff @(posedge clk) begin
        if (!rst_n || !mp_mode)          selected_q <= 1'b0;
        else if (good_frame && frm_mpb)  selected_q <= id_hit;
    end

    // Delivery decision and framing error pulse
    always_comb begin
        if (!mp_mode)     deliver = good_frame;
        else if (frm_mpb) deliver = good_frame && id_hit;
        else              deliver = good_frame && selected_q;
        fe_set = frm_valid && !frm_stop_ok;
    end

    AST_MISMATCH_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (mp_mode && good_frame && frm_mpb && !id_hit) |=> !selected_q); // R10

endmodule

// File: rtl/mp_rx_hostregs.sv
// Module: mp_rx_hostregs
// Holding register, full flag and sticky error flags seen by the host.
// Assumes: deliver and fe_set are single-cycle pulses.
module mp_rx_hostregs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deliver,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              fe_set,
    input  logic              rd_strobe,
    input  logic              err_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              frame_err,
    output logic              overrun_err
);

    // Holding register and full flag; a new character wins over a read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_full <= 1'b0;
        end else if (deliver && !rx_full) begin
            rx_data <= frm_data;
            rx_full <= 1'b1;
        end else if (rd_strobe && !deliver) begin
            rx_full <= 1'b0;
        end
    end

    // Sticky framing error flag
    always_ff @(posedge clk) begin
        if (!rst_n)       frame_err <= 1'b0;
        else if (fe_set)  frame_err <= 1'b1;
        else if (err_clr) frame_err <= 1'b0;
    end

    // Sticky overrun flag
    always_ff @(posedge clk) begin
        if (!rst_n)                  overrun_err <= 1'b0;
        else if (deliver && rx_full) overrun_err <= 1'b1;
        else if (err_clr)            overrun_err <= 1'b0;
    end

    AST_LOAD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver && !rx_full) |=> (rx_full && rx_data == $past(frm_data))); // R2
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !deliver) |=> !rx_full); // R3
    AST_FE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        fe_set |=> frame_err); // R4
    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver && rx_full) |=> (overrun_err && $stable(rx_data))); // R5

endmodule

// File: rtl/mp_serial_rx.sv
// Module: mp_serial_rx (top)
// Serial receiver for a shared line with optional node-address filtering.
// Assumes: baud_tick at 16x the bit rate, 8-bit characters, one stop bit.
module mp_serial_rx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              rxd,
    input  logic              mp_mode,
    input  logic [DATA_W-1:0] node_id,
    input  logic              rd_strobe,
    input  logic              err_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_irq,
    output logic              frame_err,
    output logic              overrun_err,
    output logic              err_irq
);

    logic              frm_valid;
    logic [DATA_W-1:0] frm_data;
    logic              frm_mpb;
    logic              frm_stop_ok;
    logic              deliver;
    logic              fe_set;

    mp_rx_sampler #(.DATA_W(DATA_W), .OVS(OVS)) u_sampler (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd(rxd), .mp_mode(mp_mode),
        .frm_valid(frm_valid), .frm_data(frm_data), .frm_mpb(frm_mpb),
        .frm_stop_ok(frm_stop_ok)
    );

    mp_rx_filter #(.DATA_W(DATA_W)) u_filter (
        .clk(clk), .rst_n(rst_n), .mp_mode(mp_mode), .node_id(node_id),
        .frm_valid(frm_valid), .frm_data(frm_data), .frm_mpb(frm_mpb),
        .frm_stop_ok(frm_stop_ok), .deliver(deliver), .fe_set(fe_set)
    );

    mp_rx_hostregs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .deliver(deliver), .frm_data(frm_data),
        .fe_set(fe_set), .rd_strobe(rd_strobe), .err_clr(err_clr),
        .rx_data(rx_data), .rx_full(rx_full), .frame_err(frame_err),
        .overrun_err(overrun_err)
    );

    // Interrupt requests are levels that follow the flags
    assign rx_irq  = rx_full;
    assign err_irq = frame_err | overrun_err;

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_err && !overrun_err) |-> !err_irq); // R11

endmodule

// File: tb/mp_serial_rx_bench.sv
module mp_serial_rx_bench;

    localparam int BIT_CLKS = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b1;
    logic       rxd = 1'b1;
    logic       mp_mode = 1'b0;
    logic [7:0] node_id = 8'h5A;
    logic       rd_strobe = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, rx_irq, frame_err, overrun_err, err_irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mp_serial_rx u_mp_serial_rx (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
        .mp_mode(mp_mode), .node_id(node_id), .rd_strobe(rd_strobe),
        .err_clr(err_clr), .rx_data(rx_data), .rx_full(rx_full),
        .rx_irq(rx_irq), .frame_err(frame_err), .overrun_err(overrun_err),
        .err_irq(err_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drives one frame bit by bit, then idles two bit times
    task automatic send_frame(input logic [7:0] d, input bit with_mpb, input bit mpb, input bit stop);
        @(negedge clk) rxd = 1'b0;
        repeat (BIT_CLKS) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (BIT_CLKS) @(negedge clk);
        end
        if (with_mpb) begin
            rxd = mpb;
            repeat (BIT_CLKS) @(negedge clk);
        end
        rxd = stop;
        repeat (BIT_CLKS) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT_CLKS) @(negedge clk);
    endtask

    task automatic host_read();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
    endtask

    task automatic clear_errors();
        @(negedge clk) err_clr = 1'b1;
        @(negedge clk) err_clr = 1'b0;
    endtask

    task automatic send_mp(input logic [7:0] d, input bit mpb);
        send_frame(d, 1'b1, mpb, 1'b1);
    endtask

    initial begin
        #(10 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rx_full", rx_full, 0);
        check("R1 rx_irq", rx_irq, 0);
        check("R1 errors", {frame_err, overrun_err, err_irq}, 0);
        check("R1 rx_data", rx_data, 0);

        // R2 R3 every byte value in plain format
        for (int v = 0; v < 256; v++) begin
            send_frame(v[7:0], 1'b0, 1'b0, 1'b1);
            check("R2 data", rx_data, v);
            check("R2 full+irq", {rx_full, rx_irq}, 2'b11);
            host_read();
            check("R3 cleared", {rx_full, rx_irq}, 2'b00);
        end

        // R6 glitch shorter than half a bit
        @(negedge clk) rxd = 1'b0;
        repeat (3) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
        check("R6 no frame", {rx_full, frame_err}, 0);

        // R4 bad stop bit
        send_frame(8'h3C, 1'b0, 1'b0, 1'b0);
        check("R4 frame_err", {frame_err, err_irq}, 2'b11);
        check("R4 full untouched", rx_full, 0);
        check("R4 data untouched", rx_data, 8'hFF);
        clear_errors();
        check("R11 fe cleared", {frame_err, err_irq}, 0);

        // R5 overrun in plain format
        send_frame(8'h12, 1'b0, 1'b0, 1'b1);
        send_frame(8'h34, 1'b0, 1'b0, 1'b1);
        check("R5 overrun", {overrun_err, err_irq}, 2'b11);
        check("R5 old data kept", rx_data, 8'h12);
        check("R5 still full", rx_full, 1);
        clear_errors();
        check("R11 ovr cleared", {overrun_err, err_irq}, 0);
        host_read();

        // R7 R8 multiprocessor format, unselected at start
        @(negedge clk) mp_mode = 1'b1;
        send_mp(8'h11, 1'b0);
        check("R8 payload skipped", rx_full, 0);
        check("R8 data unchanged", rx_data, 8'h12);
        send_mp(8'h33, 1'b1);
        check("R10 mismatch id not loaded", rx_full, 0);
        send_mp(8'h22, 1'b0);
        check("R10 payload skipped", rx_full, 0);
        send_mp(8'h5A, 1'b1);
        check("R9 id loaded", {rx_full, rx_irq, rx_data}, {2'b11, 8'h5A});
        host_read();
        send_mp(8'h77, 1'b0);
        check("R9 payload delivered", {rx_full, rx_data}, {1'b1, 8'h77});
        check("R7 no frame error", frame_err, 0);
        host_read();
        send_mp(8'h5B, 1'b1);
        check("R10 deselect id", rx_full, 0);
        send_mp(8'h44, 1'b0);
        check("R10 payload after deselect", {rx_full, rx_data}, {1'b0, 8'h77});

        // R5 overrun while selected
        send_mp(8'h5A, 1'b1);
        host_read();
        send_mp(8'h99, 1'b0);
        send_mp(8'hAA, 1'b0);
        check("R5 mp overrun", {overrun_err, rx_data}, {1'b1, 8'h99});
        clear_errors();
        host_read();

        // R10 single-bit mismatches, then R9 the exact match
        for (int k = 0; k < 9; k++) begin
            logic [7:0] idv;
            logic [7:0] pay;
            bit hit;
            hit = (k == 8);
            idv = hit ? node_id : (node_id ^ (8'h01 << k));
            pay = ~idv;
            send_mp(idv, 1'b1);
            if (hit) begin
                check("R9 sweep id", {rx_full, rx_data}, {1'b1, idv});
                host_read();
            end else begin
                check("R10 sweep id skipped", rx_full, 0);
            end
            send_mp(pay, 1'b0);
            if (hit) begin
                check("R9 sweep payload", {rx_full, rx_data}, {1'b1, pay});
                host_read();
            end else begin
                check("R10 sweep payload skipped", rx_full, 0);
            end
        end
        check("R5 no spurious overrun", overrun_err, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule